// File: doc/BRIEF.md
# Bitstream Kleene-Star Marker Sweep

The block takes two parallel bitstreams, one block of W positions per clock: a marker stream and a character-class stream. Bit j of a block stands for character j of that slice of text. A set marker bit means "the next character to match is here". The block returns a new marker stream. That stream marks every position that can be reached from some marker by stepping over zero or more consecutive class characters. This is the closure step used when a pattern element such as `[0-9]*` is matched over a whole text at once.

The sweep is built from one addition over the stream, taken as a long integer with its least significant bit at the first character. Carries travel toward later characters. A one-bit link register holds the carry out of each block and feeds it into the next block, so a run of class characters may cross block edges. A second output gives the marker stream moved one position later. Its own link bit carries the top marker bit of a block into position 0 of the next block.

A start-of-stream pulse that comes with a block clears both links for that block. Blocks may arrive with idle cycles between them. Each accepted block produces its result one cycle later.

Top module: `mstar_unit`

## Requirements
- R1: For each accepted block, `out_star` equals (((M & C) + C + k) ^ C) | M, computed over W+1 bits. M is `marker`, C is `cls`, and k is the link carry. Bit j of every stream is character j, bit 0 is the earliest character, and carries move from bit j toward bit j+1. Equivalently, out bit j = M[j] | (out[j-1] & C[j-1]), where for j = 0 the term in brackets is the link carry.
- R2: Every marker bit set in an accepted block is also set in the matching `out_star`.
- R3: The carry out of bit W-1 of one block's addition becomes k for the next accepted block of the same stream. A class run that starts in one block therefore continues to mark positions in later blocks.
- R4: When `sos` is high with an accepted block, both link bits are taken as 0 for that block: the star carry k, and bit 0 of `out_adv`.
- R5: `out_adv` bit j equals `marker` bit j-1 for j ≥ 1. Bit 0 equals `marker` bit W-1 of the previous accepted block of the stream.
- R6: A block is accepted when `in_valid` and `in_ready` are both high. `out_valid` is high exactly in the cycle after an acceptance. Cycles without acceptance change neither link bit.
- R7: While `rst_n` is low, `out_valid` and `in_ready` are 0. `in_ready` becomes 1 at the first clock edge after reset is released and stays 1.
- R8: With W = 8, the 33-character text "a453z--b3z--az--a12949z--ca22z7--" is padded with zeros to 5 blocks. The marker string ".1...........1...1.........1....." and the digit-class string ".111....1........11111.....11.1.." (character i at bit i, '1' = set) must give ".1111........1...111111....111...".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input block present |
| in_ready | output | 1 | Block can be accepted this cycle |
| sos | input | 1 | Block is the first of a new stream |
| marker | input | W | Marker stream block, bit j = character j |
| cls | input | W | Class stream block, bit j = character j |
| out_valid | output | 1 | Result block present |
| out_star | output | W | Zero-or-more closure of the markers through the class |
| out_adv | output | W | Marker stream moved one position later |

## Verification
On every cycle, the assertions check four properties of the output. Inside a block, each result bit obeys the position-by-position reachability recurrence. Input markers survive into the result. The moved stream is the input shifted by one place, with a cleared bit 0 on a stream start. Valid timing follows acceptance. Only the bench's scenarios can show how the link bits behave across block boundaries: runs that span several blocks, carries kept over idle gaps, and carries discarded on a new stream. The bench checks these against a serial reachability model. It also sweeps every marker and class pair of an 8-bit block and runs the worked text example.

// File: rtl/mstar_sweep.sv
module mstar_sweep #(
  parameter int W = 128
) (
  input  logic [W-1:0] m,
  input  logic [W-1:0] c,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);
  localparam int SW = W + 1;

  function automatic logic [SW-1:0] sweep_sum(logic [W-1:0] mk, logic [W-1:0] cl, logic ci);
    sweep_sum = {1'b0, mk & cl} + {1'b0, cl} + {{W{1'b0}}, ci};
  endfunction

  logic [SW-1:0] sum;

  always_comb begin
    sum  = sweep_sum(m, c, cin);
    res  = (sum[W-1:0] ^ c) | m;
    cout = sum[W];
  end
endmodule

// File: rtl/mstar_shift.sv
module mstar_shift #(
  parameter int W = 128
) (
  input  logic [W-1:0] m,
  input  logic         lin,
  output logic [W-1:0] res,
  output logic         lout
);
  always_comb begin
    res  = {m[W-2:0], lin};
    lout = m[W-1];
  end
endmodule

// File: rtl/mstar_link.sv
module mstar_link (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (en) q <= d;
  end

  // R6
  link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));
endmodule

// File: rtl/mstar_unit.sv
module mstar_unit #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         sos,
  input  logic [W-1:0] marker,
  input  logic [W-1:0] cls,
  output logic         out_valid,
  output logic [W-1:0] out_star,
  output logic [W-1:0] out_adv
);
  // Serial restatement of the closure, used only by the checks below.
  function automatic logic chain_ok(logic [W-1:0] r, logic [W-1:0] m, logic [W-1:0] c);
    chain_ok = 1'b1;
    for (int j = 1; j < W; j++)
      if (r[j] != (m[j] | (r[j-1] & c[j-1]))) chain_ok = 1'b0;
  endfunction

  logic         accept;
  logic         carry_q, carry_in, carry_out;
  logic         top_q, top_in, top_out;
  logic [W-1:0] star_w, adv_w;

  assign accept   = in_valid & in_ready;
  assign carry_in = sos ? 1'b0 : carry_q;
  assign top_in   = sos ? 1'b0 : top_q;

  mstar_sweep #(.W(W)) u_sweep (
    .m(marker), .c(cls), .cin(carry_in), .res(star_w), .cout(carry_out)
  );

  mstar_shift #(.W(W)) u_shift (
    .m(marker), .lin(top_in), .res(adv_w), .lout(top_out)
  );

  mstar_link u_carry (
    .clk(clk), .rst_n(rst_n), .en(accept), .d(carry_out), .q(carry_q)
  );

  mstar_link u_top (
    .clk(clk), .rst_n(rst_n), .en(accept), .d(top_out), .q(top_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_ready <= 1'b0;
    else        in_ready <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_star  <= '0;
      out_adv   <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_star <= star_w;
        out_adv  <= adv_w;
      end
    end
  end

  // R1
  star_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> chain_ok(out_star, $past(marker), $past(cls)));

  // R2
  keep_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ((out_star & $past(marker)) == $past(marker)));

  // R4
  sos_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sos) |=> !out_adv[0]);

  // R5
  adv_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_adv[W-1:1] == $past(marker[W-2:0])));

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R6
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !out_valid);

  // R7
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> !out_valid);
endmodule

// File: tb/tb_mstar_unit.sv
`timescale 1ns/1ps
module tb_mstar_unit;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         sos = 1'b0;
  logic [W-1:0] marker = '0;
  logic [W-1:0] cls = '0;
  logic         out_valid;
  logic [W-1:0] out_star, out_adv;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic lk = 1'b0;
  logic at = 1'b0;
  logic [W-1:0] last_star;

  always #2.5 clk = ~clk;

  mstar_unit #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .sos(sos), .marker(marker), .cls(cls), .out_valid(out_valid),
    .out_star(out_star), .out_adv(out_adv)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: drive a block (or an idle cycle) and check the output that follows.
  task automatic step(input logic [W-1:0] m, input logic [W-1:0] c,
                      input logic s, input logic v, input string req);
    logic [W-1:0] er, ea;
    er = '0; ea = '0;
    in_valid = v; marker = m; cls = c; sos = s;
    if (v) begin
      if (s) begin lk = 1'b0; at = 1'b0; end
      for (int j = 0; j < W; j++) begin
        er[j] = m[j] | ((j == 0) ? lk : (er[j-1] & c[j-1]));
        ea[j] = (j == 0) ? at : m[j-1];
      end
      lk = er[W-1] & c[W-1];
      at = m[W-1];
    end
    @(negedge clk);
    chk({req, " valid"}, 64'(out_valid), 64'(v));
    if (v) begin
      last_star = out_star;
      chk({req, " star"}, 64'(out_star), 64'(er));
      chk("R5 adv", 64'(out_adv), 64'(ea));
      chk("R2 keep", 64'(out_star & m), 64'(m));
    end
  endtask

  function automatic logic [39:0] s2v(string s);
    s2v = '0;
    for (int i = 0; i < s.len(); i++) if (s[i] == "1") s2v[i] = 1'b1;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<190000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    logic [39:0] got, m40, c40;
    repeat (3) @(negedge clk);
    chk("R7 reset valid", 64'(out_valid), 64'd0);
    chk("R7 reset ready", 64'(in_ready), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 ready", 64'(in_ready), 64'd1);

    // R1: every marker/class pair of one block, each a fresh stream
    for (int m = 0; m < 256; m++)
      for (int c = 0; c < 256; c++)
        step(W'(m), W'(c), 1'b1, 1'b1, "R1");

    // R3: class run crossing two block edges
    step(8'h80, 8'hFF, 1'b1, 1'b1, "R3");
    chk("R3 first", 64'(last_star), 64'h80);
    step(8'h00, 8'hFF, 1'b0, 1'b1, "R3");
    chk("R3 middle", 64'(last_star), 64'hFF);
    step(8'h00, 8'h0F, 1'b0, 1'b1, "R3");
    chk("R3 tail", 64'(last_star), 64'h1F);

    // R6: idle gaps keep the link carry
    step(8'h40, 8'hC0, 1'b1, 1'b1, "R6");
    step(8'h00, 8'h00, 1'b0, 1'b0, "R6");
    step(8'h00, 8'h00, 1'b1, 1'b0, "R6");
    step(8'h00, 8'h03, 1'b0, 1'b1, "R6");
    chk("R6 carry kept", 64'(last_star), 64'h07);

    // R4: new stream discards both links
    step(8'h80, 8'hFF, 1'b1, 1'b1, "R4");
    step(8'h00, 8'hFF, 1'b1, 1'b1, "R4");
    chk("R4 star cleared", 64'(last_star), 64'h00);
    chk("R4 adv cleared", 64'(out_adv), 64'h00);

    // R3/R4/R6 mixed pseudo-random streams
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 4000; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      step(lfsr[7:0] & lfsr[15:8], lfsr[23:16] | lfsr[31:24],
           (lfsr[29:26] == 4'd0), (lfsr[3:0] != 4'd5), "R3");
    end

    // R8: worked text example, five blocks of eight characters
    m40 = s2v(".1...........1...1.........1.....");
    c40 = s2v(".111....1........11111.....11.1..");
    got = '0;
    for (int b = 0; b < 5; b++) begin
      step(m40[8*b +: 8], c40[8*b +: 8], (b == 0), 1'b1, "R8");
      got[8*b +: 8] = last_star;
    end
    chk("R8 text", 64'(got), 64'(s2v(".1111........1...111111....111...")));

    in_valid = 1'b0;
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule